// File: doc/BRIEF.md
# Carry-Limited Approximate Adder with Recoverable Error

This block adds two unsigned operands with no carry chain longer than one bit position. Each bit pair is first rewritten into an OR term (propagate) and an AND term (generate). Moving bits between two operands at the same weight leaves the sum unchanged, so this rewrite is exact. A carry then comes only from a generate bit, and it lands only in the next higher slice. No bit has to wait for a ripple, so the logic depth is the same for every width.

Sometimes a carry arrives at a slice that would normally pass it further up. In that case the slice forces its sum bit to one and raises a bit in a separate error vector. The approximate sum and the error vector together give the exact result: adding them with any exact adder returns A + B. A consumer can use the approximate sum directly, or recover some or all of the error later. The block is purely combinational. Both outputs are one bit wider than the operands, so no carry is dropped.

Top module: `carry_cut_adder`

## Requirements
- R1: For every slice i with 1 <= i <= W-1, sum_o[i] = (a_i[i] XOR b_i[i]) OR (a_i[i-1] AND b_i[i-1]).
- R2: For every slice i with 1 <= i <= W-1, err_o[i] = (a_i[i] XOR b_i[i]) AND a_i[i-1] AND b_i[i-1].
- R3: At the lowest slice, sum_o[0] = a_i[0] XOR b_i[0] and err_o[0] = 0.
- R4: At the extra top position, sum_o[W] = a_i[W-1] AND b_i[W-1] and err_o[W] = 0.
- R5: The unsigned sum sum_o + err_o equals a_i + b_i exactly, for all operands.
- R6: sum_o, read as an unsigned number, is never greater than a_i + b_i.
- R7: No two adjacent bits of err_o are both 1.
- R8: Wherever err_o[i] is 1, sum_o[i] is also 1.
- R9: For 6-bit operands a_i = 001111 and b_i = 000110, the outputs are sum_o = 0001101 and err_o = 0001000.
- R10: When a_i AND b_i is all zeros, err_o is zero and sum_o equals a_i OR b_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First unsigned operand |
| b_i | input | W | Second unsigned operand |
| sum_o | output | W+1 | Approximate sum with carries cut after one position |
| err_o | output | W+1 | Error bits; adding them to sum_o gives the exact sum |

## Verification
Assertions are evaluated whenever the operands change. They cover these whole-word properties:
- exact recovery (R5);
- the ordering of the approximate sum against the true sum (R6);
- the ban on adjacent error bits (R7);
- an error bit implying its sum bit (R8);
- a silent error vector when no generate bit is set (R10).

The per-slice formulas, the two edge slices and the fixed worked example are shown only by the bench's scenarios (R1 to R4, R9). These scenarios are an exhaustive sweep of a 6-bit instance and a random sweep of a 16-bit instance. Both instances compare each output against values computed bit by bit from the requirements.

// File: rtl/carry_cut_pkg.sv
package carry_cut_pkg;

    // Per-position pair after operand remapping.
    typedef struct packed {
        logic prop;   // at least one operand bit set
        logic gen;    // both operand bits set
    } pg_t;

endpackage

// File: rtl/carry_cut_remap.sv
module carry_cut_remap
    import carry_cut_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output pg_t  [W-1:0] pg_o
);

    // Swapping equal-weight bits between the operands leaves the sum
    // unchanged, so OR and AND form an equivalent operand pair.
    for (genvar i = 0; i < W; i++) begin : g_pos
        assign pg_o[i].prop = a_i[i] | b_i[i];
        assign pg_o[i].gen  = a_i[i] & b_i[i];
    end

endmodule

// File: rtl/carry_cut_slice.sv
module carry_cut_slice
    import carry_cut_pkg::*;
(
    input  pg_t  pg_i,      // this position
    input  logic gen_lo_i,  // generate of the position below (carry in)
    output logic sum_o,
    output logic err_o
);

    logic passes;

    // The slice would forward the carry: propagate without generate.
    assign passes = pg_i.prop & ~pg_i.gen;

    // An arriving carry saturates the sum bit instead of moving on.
    assign sum_o = gen_lo_i | passes;
    assign err_o = gen_lo_i & passes;

endmodule

// File: rtl/carry_cut_adder.sv
module carry_cut_adder
    import carry_cut_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W:0]   sum_o,
    output logic [W:0]   err_o
);

    localparam int TOP = W;

    pg_t  [W-1:0] pg;
    logic [W-1:0] gen_lo;

    carry_cut_remap #(.W(W)) u_remap (
        .a_i  (a_i),
        .b_i  (b_i),
        .pg_o (pg)
    );

    // Each generate bit is computed once and shared by its own slice
    // (as a blocker) and the slice above (as the carry in).
    for (genvar i = 0; i < W; i++) begin : g_slice
        if (i == 0) begin : g_low
            assign gen_lo[i] = 1'b0;
        end else begin : g_mid
            assign gen_lo[i] = pg[i-1].gen;
        end

        carry_cut_slice u_slice (
            .pg_i     (pg[i]),
            .gen_lo_i (gen_lo[i]),
            .sum_o    (sum_o[i]),
            .err_o    (err_o[i])
        );
    end

    // The final carry has no slice above it to pass through.
    assign sum_o[TOP] = pg[W-1].gen;
    assign err_o[TOP] = 1'b0;

endmodule

// File: rtl/carry_cut_adder_chk.sv
module carry_cut_adder_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W:0]   sum_o,
    input logic [W:0]   err_o
);

    logic [W+1:0] true_sum;
    logic [W+1:0] recovered;

    assign true_sum  = {2'b00, a_i} + {2'b00, b_i};
    assign recovered = {1'b0, sum_o} + {1'b0, err_o};

    always_comb begin
        a_r5_exact_recovery: assert (recovered == true_sum);
        a_r6_sum_not_above: assert ({1'b0, sum_o} <= true_sum);
        a_r7_no_adjacent_err: assert ((err_o & (err_o >> 1)) == '0);
        a_r8_err_implies_sum: assert ((err_o & ~sum_o) == '0);
        if ((a_i & b_i) == '0) begin
            a_r10_no_gen_no_err: assert (err_o == '0);
        end
    end

endmodule

bind carry_cut_adder carry_cut_adder_chk #(.W(W)) u_chk (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum_o),
    .err_o (err_o)
);

// File: tb/sim_carry_cut_adder.sv
module sim_carry_cut_adder;

    localparam int CLK_PERIOD = 10;
    localparam int WS = 6;
    localparam int WL = 16;
    localparam int N_RAND = 3000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [WS-1:0] as, bs;
    logic [WS:0]   ss, es;
    logic [WL-1:0] al, bl;
    logic [WL:0]   sl, el;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    carry_cut_adder #(.W(WS)) u0 (.a_i(as), .b_i(bs), .sum_o(ss), .err_o(es));
    carry_cut_adder #(.W(WL)) u1 (.a_i(al), .b_i(bl), .sum_o(sl), .err_o(el));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected outputs from the slice rules (R1..R4), width w <= 16.
    function automatic void model(input logic [15:0] a, input logic [15:0] b, input int w,
                                  output logic [16:0] s, output logic [16:0] e);
        s = '0;
        e = '0;
        for (int i = 0; i < w; i++) begin
            logic lo;
            logic x;
            lo = (i == 0) ? 1'b0 : (a[i-1] & b[i-1]);
            x  = a[i] ^ b[i];
            s[i] = x | lo;
            e[i] = x & lo;
        end
        s[w] = a[w-1] & b[w-1];
        e[w] = 1'b0;
    endfunction

    task automatic check_all(input logic [15:0] a, input logic [15:0] b, input int w,
                             input logic [16:0] s, input logic [16:0] e);
        logic [16:0] es_exp, ee_exp;
        logic [17:0] tsum, rec;
        logic [16:0] lowmask;
        model(a, b, w, es_exp, ee_exp);
        lowmask = (17'd1 << w) - 17'd1;
        tsum = {2'b00, a} + {2'b00, b};
        rec  = {1'b0, s} + {1'b0, e};
        chk((s & lowmask & ~17'd1) == (es_exp & lowmask & ~17'd1), "R1 mid sum", 32'(s), 32'(es_exp));
        chk((e & lowmask & ~17'd1) == (ee_exp & lowmask & ~17'd1), "R2 mid err", 32'(e), 32'(ee_exp));
        chk(s[0] == (a[0] ^ b[0]) && e[0] == 1'b0, "R3 low slice", 32'({s[0], e[0]}), 32'({a[0] ^ b[0], 1'b0}));
        chk(s[w] == (a[w-1] & b[w-1]) && e[w] == 1'b0, "R4 top bit", 32'({s[w], e[w]}), 32'({a[w-1] & b[w-1], 1'b0}));
        chk(rec == tsum, "R5 recovery", 32'(rec), 32'(tsum));
        chk({1'b0, s} <= tsum, "R6 sum bound", 32'(s), 32'(tsum));
        chk((e & (e >> 1)) == '0, "R7 adjacency", 32'(e), 32'(0));
        chk((e & ~s) == '0, "R8 err under sum", 32'(e), 32'(s));
        if ((a & b) == '0) begin
            chk(e == '0 && s == {1'b0, a | b}, "R10 no generate", 32'(s), 32'(a | b));
        end
    endtask

    initial begin
        as = '0; bs = '0; al = '0; bl = '0;
        @(negedge clk);
        // Zero operands give zero outputs.
        chk(ss == '0 && es == '0 && sl == '0 && el == '0, "R5 zero state", 32'(ss), 32'(0));

        // R9: fixed worked example.
        as = 6'b001111; bs = 6'b000110;
        @(negedge clk);
        chk(ss == 7'b0001101, "R9 example sum", 32'(ss), 32'(7'b0001101));
        chk(es == 7'b0001000, "R9 example err", 32'(es), 32'(7'b0001000));

        // Exhaustive 6-bit sweep.
        for (int x = 0; x < (1 << WS); x++) begin
            for (int y = 0; y < (1 << WS); y++) begin
                as = WS'(x); bs = WS'(y);
                @(negedge clk);
                check_all(16'(as), 16'(bs), WS, 17'(ss), 17'(es));
            end
        end

        // 16-bit corners then random.
        al = '1; bl = '1;
        @(negedge clk);
        check_all(al, bl, WL, sl, el);
        al = 16'h5555; bl = 16'hAAAA;
        @(negedge clk);
        check_all(al, bl, WL, sl, el);
        al = 16'hFFFF; bl = 16'h0001;
        @(negedge clk);
        check_all(al, bl, WL, sl, el);
        for (int k = 0; k < N_RAND; k++) begin
            al = 16'($urandom); bl = 16'($urandom);
            @(negedge clk);
            check_all(al, bl, WL, sl, el);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule